// File: doc/BRIEF.md
# Forty-Bit Accumulator Register Pair

This block keeps two 40-bit accumulators for a fixed-point datapath. Each accumulator is held as three 16-bit registers: a low part, a middle part and a high part whose eight significant bits are always kept sign-extended to 16. Instruction logic can reach the accumulators in two ways. It can write or read any single 16-bit part. It can also move a whole 40-bit value in or out of either accumulator.

Part writes follow the extension rules. A high-part write keeps only the low byte of the data and sign-extends it. A middle-part write, while the 40-bit mode input is set, also fills the high part with copies of data bit 15 and clears the low part, so the accumulator then holds the value sign-extended from 16 bits. Whole-value reads return the 40-bit contents sign-extended onto a wider bus. Every register updates on the rising clock. All reads are combinational from the stored state.

Top module: `acc_pair_regs`

## Requirements
- R1: After the asynchronous active-low reset, all six part registers read zero and both wide outputs are zero.
- R2: A part write with wr_part_i = 0 (low part) stores wr_data_i into the low part of accumulator wr_acc_i, and the other two parts keep their values.
- R3: A part write with wr_part_i = 2 (high part) stores wr_data_i[7:0] sign-extended to 16 bits, whatever bits 15:8 of the data are. The low and middle parts are unchanged.
- R4: A part write with wr_part_i = 1 (middle part) while mode40_i is 0 stores wr_data_i into the middle part and changes nothing else.
- R5: A middle-part write while mode40_i is 1 stores wr_data_i into the middle part, sets the high part to 16'hFFFF if wr_data_i[15] is 1 or to 16'h0000 otherwise, and clears the low part.
- R6: A wide write, wide_we_i[n] = 1, stores value bits 15:0 into the low part and bits 31:16 into the middle part of accumulator n. It stores bits 39:32, sign-extended to 16 bits, into the high part.
- R7: wide_rdata_o[n] holds {high[7:0], middle, low} of accumulator n in bits 39:0, with bit 39 copied into every bit above it.
- R8: When a wide write and a part write target the same accumulator in one cycle, only the wide write takes effect. A part write to the other accumulator in that cycle still takes effect.
- R9: rd_data_o returns the selected 16-bit part of accumulator rd_acc_i (0 low, 1 middle, 2 high). Select code 3 reads as zero. A part write with code 3 changes no register.
- R10: A write to one accumulator never changes the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode40_i | input | 1 | 40-bit mode: middle-part writes extend across the accumulator |
| wr_en_i | input | 1 | Part write enable |
| wr_acc_i | input | 1 | Accumulator index for the part write |
| wr_part_i | input | 2 | Part select for the write (0 low, 1 middle, 2 high, 3 none) |
| wr_data_i | input | 16 | Part write data |
| wide_we_i | input | 2 | Wide write enable, one bit per accumulator |
| wide_wdata_i | input | 2x40 | Wide write value, one per accumulator |
| rd_acc_i | input | 1 | Accumulator index for the part read |
| rd_part_i | input | 2 | Part select for the read |
| rd_data_o | output | 16 | Selected part |
| wide_rdata_o | output | 2x64 | Accumulator values, sign-extended from bit 39 |

## Verification
The bench starts with directed writes. High-byte data with the sign bit both set and clear, and with junk in the upper data byte, separates true extension from plain storage. Middle-part writes are made with the mode both off and on and with either data sign, so a missing high fill, an inverted fill and an uncleared low part each give different wrong results. Collision cycles put a wide write and a part write on the same accumulator and then on different accumulators, which tells a reversed priority from a priority that also blocks the other accumulator. A long stretch of random traffic then sweeps every part through the read select after every write and compares against the reference model, which exposes any leakage between the two accumulators.

// File: rtl/acc_pair_pkg.sv
package acc_pair_pkg;
  parameter int unsigned PART_W  = 16;
  parameter int unsigned HI_BITS = 8;
  parameter int unsigned ACC_W   = 2 * PART_W + HI_BITS;
  parameter int unsigned NUM_ACC = 2;

  typedef enum logic [1:0] {
    PART_LO   = 2'd0,
    PART_MID  = 2'd1,
    PART_HI   = 2'd2,
    PART_NONE = 2'd3
  } part_e;

  typedef struct packed {
    logic [PART_W-1:0] hi;
    logic [PART_W-1:0] mid;
    logic [PART_W-1:0] lo;
  } acc_regs_t;
endpackage

// File: rtl/acc_slice.sv
module acc_slice
  import acc_pair_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode40_i,
  input  logic             wr_en_i,
  input  part_e            part_i,
  input  logic [PART_W-1:0] data_i,
  input  logic             wide_we_i,
  input  logic [ACC_W-1:0] wide_data_i,
  output acc_regs_t        regs_o
);
  localparam int unsigned EXT_W  = PART_W - HI_BITS;
  localparam int unsigned MID_LO = PART_W;
  localparam int unsigned HI_LO  = 2 * PART_W;

  acc_regs_t regs_q, regs_d;

  always_comb begin
    regs_d = regs_q;
    if (wide_we_i) begin
      regs_d.lo  = wide_data_i[MID_LO-1:0];
      regs_d.mid = wide_data_i[HI_LO-1:MID_LO];
      regs_d.hi  = {{EXT_W{wide_data_i[ACC_W-1]}}, wide_data_i[ACC_W-1:HI_LO]};
    end else if (wr_en_i) begin
      unique case (part_i)
        PART_LO:  regs_d.lo = data_i;
        PART_MID: begin
          regs_d.mid = data_i;
          if (mode40_i) begin
            regs_d.hi = {PART_W{data_i[PART_W-1]}};
            regs_d.lo = '0;
          end
        end
        PART_HI:  regs_d.hi = {{EXT_W{data_i[HI_BITS-1]}}, data_i[HI_BITS-1:0]};
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) regs_q <= '0;
    else         regs_q <= regs_d;
  end

  assign regs_o = regs_q;

  a_r3_hi_sign_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regs_q.hi[PART_W-1:HI_BITS] == {EXT_W{regs_q.hi[HI_BITS-1]}});

  a_r8_wide_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wide_we_i |=> (regs_q.lo == $past(wide_data_i[MID_LO-1:0]))
               && (regs_q.mid == $past(wide_data_i[HI_LO-1:MID_LO]))
               && (regs_q.hi[HI_BITS-1:0] == $past(wide_data_i[ACC_W-1:HI_LO])));

  a_r5_mid_extend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wide_we_i && part_i == PART_MID && mode40_i)
      |=> (regs_q.lo == '0) && (regs_q.hi == {PART_W{$past(data_i[PART_W-1])}}));

  a_r4_mid_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wide_we_i && part_i == PART_MID && !mode40_i)
      |=> $stable(regs_q.lo) && $stable(regs_q.hi));

  a_r9_none_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!wr_en_i || part_i == PART_NONE) && !wide_we_i) |=> $stable(regs_q));
endmodule

// File: rtl/acc_read_mux.sv
module acc_read_mux
  import acc_pair_pkg::*;
#(
  parameter int unsigned IDX_W = 1
) (
  input  acc_regs_t [NUM_ACC-1:0] regs_i,
  input  logic [IDX_W-1:0]        acc_i,
  input  part_e                   part_i,
  output logic [PART_W-1:0]       data_o
);
  acc_regs_t sel;

  always_comb begin
    sel = regs_i[acc_i];
    unique case (part_i)
      PART_LO:  data_o = sel.lo;
      PART_MID: data_o = sel.mid;
      PART_HI:  data_o = sel.hi;
      default:  data_o = '0;
    endcase
  end
endmodule

// File: rtl/acc_wide_view.sv
module acc_wide_view
  import acc_pair_pkg::*;
#(
  parameter int unsigned OUT_W = 64
) (
  input  acc_regs_t        regs_i,
  output logic [OUT_W-1:0] wide_o
);
  localparam int unsigned PAD_W = OUT_W - ACC_W;

  logic [ACC_W-1:0] raw;
  assign raw    = {regs_i.hi[HI_BITS-1:0], regs_i.mid, regs_i.lo};
  assign wide_o = {{PAD_W{raw[ACC_W-1]}}, raw};
endmodule

// File: rtl/acc_pair_regs.sv
module acc_pair_regs
  import acc_pair_pkg::*;
#(
  parameter int unsigned OUT_W = 64,
  parameter int unsigned IDX_W = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              mode40_i,
  input  logic                              wr_en_i,
  input  logic [IDX_W-1:0]                  wr_acc_i,
  input  logic [1:0]                        wr_part_i,
  input  logic [PART_W-1:0]                 wr_data_i,
  input  logic [NUM_ACC-1:0]                wide_we_i,
  input  logic [NUM_ACC-1:0][ACC_W-1:0]     wide_wdata_i,
  input  logic [IDX_W-1:0]                  rd_acc_i,
  input  logic [1:0]                        rd_part_i,
  output logic [PART_W-1:0]                 rd_data_o,
  output logic [NUM_ACC-1:0][OUT_W-1:0]     wide_rdata_o
);
  acc_regs_t [NUM_ACC-1:0] regs;

  for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
    logic sel_wr;
    assign sel_wr = wr_en_i && (wr_acc_i == IDX_W'(g));

    acc_slice u_slice (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .mode40_i    (mode40_i),
      .wr_en_i     (sel_wr),
      .part_i      (part_e'(wr_part_i)),
      .data_i      (wr_data_i),
      .wide_we_i   (wide_we_i[g]),
      .wide_data_i (wide_wdata_i[g]),
      .regs_o      (regs[g])
    );

    acc_wide_view #(.OUT_W(OUT_W)) u_view (
      .regs_i (regs[g]),
      .wide_o (wide_rdata_o[g])
    );

    a_r7_wide_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wide_rdata_o[g][OUT_W-1:ACC_W-1] == {(OUT_W-ACC_W+1){regs[g].hi[HI_BITS-1]}});

    a_r10_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wide_we_i[g] && !(wr_en_i && wr_acc_i == IDX_W'(g)))
        |=> $stable(wide_rdata_o[g]));
  end

  acc_read_mux #(.IDX_W(IDX_W)) u_rd (
    .regs_i (regs),
    .acc_i  (rd_acc_i),
    .part_i (part_e'(rd_part_i)),
    .data_o (rd_data_o)
  );
endmodule

// File: tb/acc_pair_regs_test.sv
`timescale 1ns/100ps
module acc_pair_regs_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              mode40 = 0, wr_en = 0, wr_acc = 0, rd_acc = 0;
  logic [1:0]        wr_part = 0, rd_part = 0, wide_we = 0;
  logic [15:0]       wr_data = 0;
  logic [1:0][39:0]  wide_wd = '0;
  logic [15:0]       rd_data;
  logic [1:0][63:0]  wide_rd;

  acc_pair_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .mode40_i(mode40), .wr_en_i(wr_en),
    .wr_acc_i(wr_acc), .wr_part_i(wr_part), .wr_data_i(wr_data),
    .wide_we_i(wide_we), .wide_wdata_i(wide_wd), .rd_acc_i(rd_acc),
    .rd_part_i(rd_part), .rd_data_o(rd_data), .wide_rdata_o(wide_rd)
  );

  int checks = 0, errors = 0, cycles = 0;
  logic [15:0] m_hi[2], m_mid[2], m_lo[2];

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic verify_all(input string tag);
    for (int a = 0; a < 2; a++) begin
      for (int p = 0; p < 4; p++) begin
        logic [15:0] e;
        rd_acc = a[0]; rd_part = p[1:0];
        #0.2;
        e = (p == 0) ? m_lo[a] : (p == 1) ? m_mid[a] : (p == 2) ? m_hi[a] : 16'h0;
        chk($sformatf("%s R9 rd acc%0d part%0d", tag, a, p), {48'h0, rd_data}, e);
      end
      chk($sformatf("%s R7 wide acc%0d", tag, a), wide_rd[a],
          {{24{m_hi[a][7]}}, m_hi[a][7:0], m_mid[a], m_lo[a]});
    end
  endtask

  // reference update for one clock with the given inputs
  task automatic model(input logic en, input logic acc, input logic [1:0] part,
                       input logic [15:0] d, input logic [1:0] we,
                       input logic [1:0][39:0] wd, input logic md);
    for (int a = 0; a < 2; a++) begin
      if (we[a]) begin
        m_lo[a]  = wd[a][15:0];
        m_mid[a] = wd[a][31:16];
        m_hi[a]  = 16'($signed(wd[a][39:32]));
      end else if (en && acc == a[0]) begin
        case (part)
          2'd0: m_lo[a] = d;
          2'd1: begin
            m_mid[a] = d;
            if (md) begin m_hi[a] = d[15] ? 16'hFFFF : 16'h0000; m_lo[a] = 16'h0; end
          end
          2'd2: m_hi[a] = 16'($signed(d[7:0]));
          default: ;
        endcase
      end
    end
  endtask

  task automatic step(input string tag, input logic en, input logic acc,
                      input logic [1:0] part, input logic [15:0] d,
                      input logic [1:0] we, input logic [39:0] w0,
                      input logic [39:0] w1, input logic md);
    @(negedge clk);
    wr_en = en; wr_acc = acc; wr_part = part; wr_data = d;
    wide_we = we; wide_wd[0] = w0; wide_wd[1] = w1; mode40 = md;
    model(en, acc, part, d, we, wide_wd, md);
    @(negedge clk);
    wr_en = 0; wide_we = 0;
    verify_all(tag);
  endtask

  initial begin
    for (int a = 0; a < 2; a++) begin m_hi[a] = 0; m_mid[a] = 0; m_lo[a] = 0; end
    #1;
    verify_all("R1 in-reset");
    #20 rst_n = 1'b1;
    @(negedge clk);
    verify_all("R1 after-reset");

    step("R2 lo write",        1, 0, 2'd0, 16'hA5C3, 2'b00, 0, 0, 0);
    step("R3 hi neg junk",     1, 0, 2'd2, 16'h3C80, 2'b00, 0, 0, 0);
    step("R3 hi pos junk",     1, 1, 2'd2, 16'hFF7F, 2'b00, 0, 0, 0);
    step("R4 mid mode off",    1, 0, 2'd1, 16'h8001, 2'b00, 0, 0, 0);
    step("R5 mid neg mode on", 1, 0, 2'd1, 16'h9234, 2'b00, 0, 0, 1);
    step("R2 lo refill",       1, 0, 2'd0, 16'h1111, 2'b00, 0, 0, 1);
    step("R5 mid pos mode on", 1, 0, 2'd1, 16'h7FFF, 2'b00, 0, 0, 1);
    step("R6 wide neg acc1",   0, 0, 2'd0, 0, 2'b10, 0, 40'h80_1234_5678, 0);
    step("R6 wide pos acc0",   0, 0, 2'd0, 0, 2'b01, 40'h7F_ABCD_EF01, 0, 0);
    step("R8 same acc",        1, 0, 2'd0, 16'hDEAD, 2'b01, 40'hC3_0F0F_F0F0, 0, 0);
    step("R8 other acc",       1, 1, 2'd0, 16'hBEEF, 2'b01, 40'h01_2222_3333, 0, 1);
    step("R8 both wide",       1, 1, 2'd1, 16'hFFFF, 2'b11, 40'hFF_FFFF_FFFF, 40'h00_8000_0001, 1);
    step("R9 code3 ignored",   1, 0, 2'd3, 16'hFFFF, 2'b00, 0, 0, 1);
    step("R10 acc1 only",      1, 1, 2'd1, 16'h8000, 2'b00, 0, 0, 1);

    for (int i = 0; i < 3000; i++) begin
      step("R10 random", $urandom_range(0, 1) == 1, 1'($urandom), 2'($urandom),
           16'($urandom), 2'($urandom_range(0, 3) & ($urandom_range(0, 2) == 0 ? 3 : 0)),
           {8'($urandom), 32'($urandom)}, {8'($urandom), 32'($urandom)},
           1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule